// File: doc/BRIEF.md
# Flash Security State Register

This block holds the security configuration of a flash-based controller. After reset it requests the security byte from the nonvolatile configuration area. The byte comes back through a flash read interface, together with a flag that marks an uncorrectable read fault. The block keeps the byte in an 8-bit register that software can read. From that register it decodes two outputs: whether backdoor key access is permitted, and whether the device is secured. A separate key comparison unit sends a one-cycle pulse when a backdoor unlock succeeds. On that pulse the block forces its security field to the unsecured code, and it stays unsecured until the next reset.

A small state machine sequences the block. There are four states:
- `ST_ISSUE` requests the flash read.
- `ST_AWAIT` waits for the returned byte.
- `ST_ARMED` means the byte is loaded and no unlock has happened yet.
- `ST_OPENED` means the backdoor unlock has been applied.

There are three transitions:
- `T_ISSUE_DONE` runs from `ST_ISSUE` to `ST_AWAIT` unconditionally.
- `T_CAPTURE` runs from `ST_AWAIT` to `ST_ARMED` when the flash byte is valid.
- `T_UNLOCK` runs from `ST_ARMED` to `ST_OPENED` when an unlock pulse arrives while key access is enabled.

Every other case holds the current state. Only reset returns the machine to `ST_ISSUE`.

Register layout:
- bits 7:6 are the key-enable field.
- bits 5:2 are reserved bits.
- bits 1:0 are the security field.

Top module: `flash_sec_reg`

## Requirements
- R1: From reset until the flash byte is captured, the register reads 8'hFF, `load_done` is 0, `secured` is 1 and `key_access_en` is 0. `cfg_rd_req` is high during the first cycle after reset is released.
- R2: While the block waits for the byte, a cycle with `cfg_valid` high and `cfg_dbl_err` low stores `cfg_byte` in the register. `load_done` rises after the same clock edge.
- R3: If `cfg_dbl_err` is high in the capture cycle, the register is set to 8'hFF, whatever `cfg_byte` holds.
- R4: `key_access_en` is 1 only when the load is done and bits 7:6 equal 2'b10. The codes 2'b00, 2'b01 and 2'b11 give 0.
- R5: `secured` is 0 only when the load is done and bits 1:0 equal 2'b10. Every other code gives 1.
- R6: An `unlock_pulse` while `key_access_en` is 1 forces bits 1:0 to 2'b10 at that clock edge. Bits 7:2 are left unchanged.
- R7: An `unlock_pulse` is ignored, and leaves the register unchanged, while `key_access_en` is 0. This includes the time before the load completes.
- R8: Bus writes (`bus_wr_en`, `bus_wr_data`) never change the register.
- R9: Bits 5:2 are stored and read back exactly as loaded, including values other than all ones.
- R10: After the capture, further `cfg_valid` cycles are ignored. The unsecured state forced by an unlock persists until reset, and reset restores the state of R1.
- R11: `rd_data` shows the register when `bus_rd_en` is 1 and 8'h00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_req | output | 1 | Request to read the security byte from flash |
| cfg_valid | input | 1 | Flash read data valid |
| cfg_byte | input | 8 | Security byte from the flash configuration area |
| cfg_dbl_err | input | 1 | Uncorrectable fault on the flash read |
| unlock_pulse | input | 1 | Successful backdoor unlock, one cycle |
| bus_rd_en | input | 1 | Register read select |
| bus_wr_en | input | 1 | Register write strobe (ignored) |
| bus_wr_data | input | 8 | Register write data (ignored) |
| rd_data | output | 8 | Register read data |
| load_done | output | 1 | Security byte has been captured |
| key_access_en | output | 1 | Backdoor key access permitted |
| secured | output | 1 | Device is in the secured state |

## Verification
The bench loads bytes with every key-enable code and several security codes. This catches a decoder that treats any nonzero key code as enabled, or that treats security code 01 as unsecured. It loads bytes with a fault flag whose payload would otherwise unsecure the device, or enable key access. A design that ignores the flag would leak access there. It sends unlock pulses before the load, with disabled key codes, and after a prior unlock. A design that skips the gating, or that clobbers bits 7:2 when it forces the security field, would show a wrong read value. It also replays `cfg_valid` after the capture and attempts writes. A design that captures again or accepts the writes would show a changed register.

// File: rtl/flash_sec_pkg.sv
package flash_sec_pkg;

    localparam int REG_W     = 8;
    localparam int KEY_HI    = 7;
    localparam int KEY_LO    = 6;
    localparam int RSV_HI    = 5;
    localparam int RSV_LO    = 2;
    localparam int SEC_HI    = 1;
    localparam int SEC_LO    = 0;
    localparam int KEY_W     = KEY_HI - KEY_LO + 1;
    localparam int SEC_W     = SEC_HI - SEC_LO + 1;

    localparam logic [KEY_W-1:0] KEY_OPEN_CODE = 2'b10;
    localparam logic [SEC_W-1:0] SEC_OPEN_CODE = 2'b10;
    localparam logic [REG_W-1:0] REG_PENDING   = '1;
    localparam logic [REG_W-1:0] REG_FAULT     = '1;

    typedef enum logic [1:0] {
        ST_ISSUE  = 2'd0,
        ST_AWAIT  = 2'd1,
        ST_ARMED  = 2'd2,
        ST_OPENED = 2'd3
    } sec_state_e;

    typedef struct packed {
        logic cfg_rd_req;
        logic cap_en;
        logic force_en;
        logic load_done;
    } sec_ctrl_t;

    function automatic logic [KEY_W-1:0] key_field(input logic [REG_W-1:0] v);
        return v[KEY_HI:KEY_LO];
    endfunction

    function automatic logic [SEC_W-1:0] sec_field(input logic [REG_W-1:0] v);
        return v[SEC_HI:SEC_LO];
    endfunction

endpackage

// File: rtl/flash_sec_fsm.sv
module flash_sec_fsm
    import flash_sec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_valid,
    input  logic      unlock_pulse,
    input  logic      key_ok,
    output sec_ctrl_t ctrl
);

    sec_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ISSUE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ISSUE:  state_d = ST_AWAIT;                       // T_ISSUE_DONE
            ST_AWAIT:  if (cfg_valid) state_d = ST_ARMED;        // T_CAPTURE
            ST_ARMED:  if (unlock_pulse && key_ok) state_d = ST_OPENED; // T_UNLOCK
            ST_OPENED: state_d = ST_OPENED;
            default:   state_d = ST_ISSUE;
        endcase
    end

    // Output logic
    always_comb begin
        ctrl = '0;
        unique case (state_q)
            ST_ISSUE: begin
                ctrl.cfg_rd_req = 1'b1;
            end
            ST_AWAIT: begin
                ctrl.cap_en = cfg_valid;
            end
            ST_ARMED: begin
                ctrl.load_done = 1'b1;
                ctrl.force_en  = unlock_pulse && key_ok;
            end
            ST_OPENED: begin
                ctrl.load_done = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/flash_sec_store.sv
module flash_sec_store
    import flash_sec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             force_en,
    input  logic [REG_W-1:0] load_byte,
    input  logic             load_fault,
    output logic [REG_W-1:0] sec_q
);

    logic [REG_W-1:0] sec_d;

    always_comb begin
        sec_d = sec_q;
        if (cap_en) begin
            sec_d = load_fault ? REG_FAULT : load_byte;
        end else if (force_en) begin
            sec_d[SEC_HI:SEC_LO] = SEC_OPEN_CODE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= REG_PENDING;
        end else begin
            sec_q <= sec_d;
        end
    end

endmodule

// File: rtl/flash_sec_decode.sv
module flash_sec_decode
    import flash_sec_pkg::*;
(
    input  logic [REG_W-1:0] sec_q,
    input  logic             load_done,
    output logic             key_ok,
    output logic             secured
);

    always_comb begin
        key_ok  = load_done && (key_field(sec_q) == KEY_OPEN_CODE);
        secured = !(load_done && (sec_field(sec_q) == SEC_OPEN_CODE));
    end

endmodule

// File: rtl/flash_sec_reg.sv
module flash_sec_reg
    import flash_sec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic             cfg_rd_req,
    input  logic             cfg_valid,
    input  logic [REG_W-1:0] cfg_byte,
    input  logic             cfg_dbl_err,
    input  logic             unlock_pulse,
    input  logic             bus_rd_en,
    input  logic             bus_wr_en,
    input  logic [REG_W-1:0] bus_wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             load_done,
    output logic             key_access_en,
    output logic             secured
);

    sec_ctrl_t        ctrl;
    logic [REG_W-1:0] sec_q;
    logic             key_ok;
    logic             unused_wr;

    // The register is read-only: the write port is accepted and discarded.
    assign unused_wr = ^{bus_wr_en, bus_wr_data};

    flash_sec_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_valid    (cfg_valid),
        .unlock_pulse (unlock_pulse),
        .key_ok       (key_ok),
        .ctrl         (ctrl)
    );

    flash_sec_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (ctrl.cap_en),
        .force_en   (ctrl.force_en),
        .load_byte  (cfg_byte),
        .load_fault (cfg_dbl_err),
        .sec_q      (sec_q)
    );

    flash_sec_decode u_dec (
        .sec_q     (sec_q),
        .load_done (ctrl.load_done),
        .key_ok    (key_ok),
        .secured   (secured)
    );

    assign cfg_rd_req    = ctrl.cfg_rd_req;
    assign load_done     = ctrl.load_done;
    assign key_access_en = key_ok;
    assign rd_data       = bus_rd_en ? sec_q : '0;

endmodule

// File: rtl/flash_sec_chk.sv
module flash_sec_chk
    import flash_sec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_valid,
    input logic             cfg_dbl_err,
    input logic             unlock_pulse,
    input logic             bus_rd_en,
    input logic [REG_W-1:0] rd_data,
    input logic [REG_W-1:0] sec_q,
    input logic             load_done,
    input logic             key_access_en,
    input logic             secured
);

    assert_pending_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_done && bus_rd_en) |-> (rd_data == REG_PENDING));

    assert_fault_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_done && cfg_valid && cfg_dbl_err) |=> (sec_q == REG_FAULT));

    assert_key_needs_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        key_access_en |-> load_done);

    assert_open_needs_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !secured |-> load_done);

    assert_unlock_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_pulse && key_access_en) |=>
            (sec_q[SEC_HI:SEC_LO] == SEC_OPEN_CODE) && $stable(sec_q[KEY_HI:RSV_LO]));

    assert_unlock_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && unlock_pulse && !key_access_en) |=> $stable(sec_q));

    assert_load_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> (load_done && $stable(sec_q[KEY_HI:RSV_LO])));

    assert_rd_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |-> (rd_data == '0));

endmodule

bind flash_sec_reg flash_sec_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_valid     (cfg_valid),
    .cfg_dbl_err   (cfg_dbl_err),
    .unlock_pulse  (unlock_pulse),
    .bus_rd_en     (bus_rd_en),
    .rd_data       (rd_data),
    .sec_q         (sec_q),
    .load_done     (load_done),
    .key_access_en (key_access_en),
    .secured       (secured)
);

// File: tb/tb_flash_sec_reg.sv
module tb_flash_sec_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_rd_req;
    logic       cfg_valid = 1'b0;
    logic [7:0] cfg_byte = 8'h00;
    logic       cfg_dbl_err = 1'b0;
    logic       unlock_pulse = 1'b0;
    logic       bus_rd_en = 1'b1;
    logic       bus_wr_en = 1'b0;
    logic [7:0] bus_wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       load_done;
    logic       key_access_en;
    logic       secured;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_sec_reg dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_rd_req    (cfg_rd_req),
        .cfg_valid     (cfg_valid),
        .cfg_byte      (cfg_byte),
        .cfg_dbl_err   (cfg_dbl_err),
        .unlock_pulse  (unlock_pulse),
        .bus_rd_en     (bus_rd_en),
        .bus_wr_en     (bus_wr_en),
        .bus_wr_data   (bus_wr_data),
        .rd_data       (rd_data),
        .load_done     (load_done),
        .key_access_en (key_access_en),
        .secured       (secured)
    );

    // {byte, fault, unlock, exp_rd, exp_key, exp_secured}
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {8'hFE, 1'b0, 1'b0, 8'hFE, 1'b0, 1'b0},
        {8'hBF, 1'b0, 1'b0, 8'hBF, 1'b1, 1'b1},
        {8'hBF, 1'b0, 1'b1, 8'hBE, 1'b1, 1'b0},
        {8'h7F, 1'b0, 1'b1, 8'h7F, 1'b0, 1'b1},
        {8'h3C, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b1},
        {8'h80, 1'b0, 1'b1, 8'h82, 1'b1, 1'b0},
        {8'hBD, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b1},
        {8'hC1, 1'b0, 1'b0, 8'hC1, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reset; returns at the negedge of the first cycle after release (ST_ISSUE).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_valid = 1'b0;
        unlock_pulse = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called in ST_ISSUE cycle; captures at the edge after the next negedge.
    task automatic do_load(input logic [7:0] b, input logic err);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_byte = b;
        cfg_dbl_err = err;
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_dbl_err = 1'b0;
    endtask

    task automatic do_unlock();
        unlock_pulse = 1'b1;
        @(negedge clk);
        unlock_pulse = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1: pending state, first cycle after reset
        check("R1 req", {7'd0, cfg_rd_req}, 8'h01);
        check("R1 rd", rd_data, 8'hFF);
        check("R1 done", {7'd0, load_done}, 8'h00);
        check("R1 secured", {7'd0, secured}, 8'h01);
        check("R1 key", {7'd0, key_access_en}, 8'h00);

        // Vector table: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            do_reset();
            do_load(VEC[i][19:12], VEC[i][11]);
            check("R2 done", {7'd0, load_done}, 8'h01);
            if (VEC[i][10]) do_unlock();
            check("R2/R3/R6/R7/R9 rd", rd_data, VEC[i][9:2]);
            check("R4 key", {7'd0, key_access_en}, {7'd0, VEC[i][1]});
            check("R5 secured", {7'd0, secured}, {7'd0, VEC[i][0]});
        end

        // R7: unlock before load is ignored
        do_reset();
        @(negedge clk);
        unlock_pulse = 1'b1;
        check("R7 pre-load rd", rd_data, 8'hFF);
        @(negedge clk);
        unlock_pulse = 1'b0;
        check("R7 pre-load rd after", rd_data, 8'hFF);
        cfg_valid = 1'b1;
        cfg_byte = 8'hB3;
        @(negedge clk);
        cfg_valid = 1'b0;
        check("R7 pre-load no force", rd_data, 8'hB3);
        check("R5 code 11 secured", {7'd0, secured}, 8'h01);

        // R8: writes ignored
        bus_wr_en = 1'b1;
        bus_wr_data = 8'h02;
        @(negedge clk);
        bus_wr_data = 8'h00;
        @(negedge clk);
        bus_wr_en = 1'b0;
        check("R8 write ignored", rd_data, 8'hB3);

        // R11: read gating
        bus_rd_en = 1'b0;
        #1;
        check("R11 rd gated", rd_data, 8'h00);
        bus_rd_en = 1'b1;
        #1;
        check("R11 rd open", rd_data, 8'hB3);

        // R10: second cfg_valid after load ignored; unlock persists
        do_unlock();
        check("R6 unlock", rd_data, 8'hB2);
        cfg_valid = 1'b1;
        cfg_byte = 8'h7F;
        @(negedge clk);
        cfg_valid = 1'b0;
        do_unlock();
        repeat (3) @(negedge clk);
        check("R10 persist rd", rd_data, 8'hB2);
        check("R10 persist secured", {7'd0, secured}, 8'h00);

        // R10: reset restores pending state
        do_reset();
        check("R10 reset rd", rd_data, 8'hFF);
        check("R10 reset secured", {7'd0, secured}, 8'h01);
        check("R10 reset done", {7'd0, load_done}, 8'h00);

        // R3: fault with an enabling payload leaves key access off
        do_load(8'h82, 1'b1);
        check("R3 fault rd", rd_data, 8'hFF);
        check("R3 fault key", {7'd0, key_access_en}, 8'h00);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule